// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirector

The block turns a group of wired interrupt inputs into single-beat interrupt messages. Each message is an address and data pair meant for a memory-write path toward a processor. Every input line owns a two-word redirection entry. The low word holds the message data byte, polarity, trigger mode and a mask bit. The high word holds an 8-bit destination ID and an 8-bit extended ID, which are merged into the message address.

Software reaches the entries indirectly. It writes an index to a select register at byte offset 0x00 and then reads or writes the chosen word through a window at offset 0x10. A write to offset 0x40 acts as end-of-interrupt. Edge-mode lines send one message for each assertion. A level-mode line sends one message and then stays in service until software writes that line's data byte to the end-of-interrupt register. Inputs are synchronized, polarity-corrected and arbitrated lowest line first onto a valid/ready output.

Top module: `irq_msg_redirector`

## Requirements
- R1: After reset, msg_valid is 0, the select register reads 0, every entry low word reads 0x00010000 (masked) and every high word reads 0.
- R2: Window index 0x01 reads {8'h00, NUM_LINES-1, 8'h00, VERSION}. Writes to it have no effect.
- R3: Line i has its low word at index 0x10+2*i and its high word at index 0x11+2*i. A window read returns the last value written there. Any other index reads 0 and ignores writes.
- R4: The message address is MSG_BASE OR ({high[31:24], high[23:16]} << 12). The message data is {24'h0, low[7:0]}.
- R5: With low bit 15 = 0 (edge mode), each new assertion of a line yields exactly one message, and holding the line asserted yields no more.
- R6: With low bit 15 = 1 (level mode), a line yields one message and then none while it stays asserted. An EOI write with a matching data byte re-arms the line: it sends again if the line is still asserted, and sends nothing if the line has been released.
- R7: An EOI write re-arms only the level entries whose data byte equals wdata[7:0]. Other in-service lines stay blocked.
- R8: Low bit 13 = 1 makes a line active-low: input 0 is asserted and input 1 is idle.
- R9: Low bit 16 = 1 suppresses messages. An edge seen while masked is kept pending and is sent once the mask is cleared.
- R10: When several lines request at once, the lowest line number goes first. A message stays valid with stable address and data until msg_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (0x00 select, 0x10 window, 0x40 EOI) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_in | input | NUM_LINES | Asynchronous interrupt lines |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message data |

## Verification
Edge-mode lines are driven with a held assertion and then a release and re-assertion. This separates one message per edge from repeated messages on a held line. Level-mode lines receive EOI writes both while still asserted and after release, which tells re-arming apart from spurious messages. Two level lines with different data bytes show that an EOI acts only on matching entries. Active-low inputs, edges that arrive while masked, and simultaneous requests under back-pressure each show a different part of the request path: polarity, pending retention, and arbitration order with output hold.

// File: rtl/irq_msg_redirector.sv
module irq_msg_redirector #(
  parameter int          NUM_LINES = 8,
  parameter logic [7:0]  VERSION   = 8'h21,
  parameter logic [31:0] MSG_BASE  = 32'hF000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [31:0]          msg_addr,
  output logic [31:0]          msg_data
);
  localparam int         LW       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [7:0] FIRST    = 8'h10;
  localparam logic [7:0] LAST     = 8'(16 + 2*NUM_LINES - 1);
  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_WIN  = 8'h10;
  localparam logic [7:0] OFF_EOI  = 8'h40;
  localparam int         B_MASK   = 16;
  localparam int         B_LEVEL  = 15;
  localparam int         B_POLLO  = 13;

  logic [31:0] lo_q [NUM_LINES];
  logic [31:0] hi_q [NUM_LINES];
  logic [7:0]  sel_q;
  logic [NUM_LINES-1:0] sync1_q, sync2_q, asrt, asrt_q, pend_q, insvc_q;
  logic [NUM_LINES-1:0] lvl, req, grant, eoi_hit;
  logic [LW-1:0] win_idx, sel_line;
  logic [7:0]    sel_rel;
  logic          sel_entry, issue, eoi_wr;
  logic [31:0]   ver_word, win_val;

  assign sel_entry = (sel_q >= FIRST) && (sel_q <= LAST);
  assign sel_rel   = sel_q - FIRST;
  assign sel_line  = sel_rel[LW:1];
  assign ver_word  = {8'h00, 8'(NUM_LINES-1), 8'h00, VERSION};
  assign win_val   = sel_entry ? (sel_q[0] ? hi_q[sel_line] : lo_q[sel_line])
                   : (sel_q == 8'h01) ? ver_word : 32'h0;
  assign reg_rdata = (reg_addr == OFF_SEL) ? {24'h0, sel_q}
                   : (reg_addr == OFF_WIN) ? win_val : 32'h0;
  assign eoi_wr    = reg_wr && (reg_addr == OFF_EOI);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign lvl[g]     = lo_q[g][B_LEVEL];
    assign asrt[g]    = sync2_q[g] ^ lo_q[g][B_POLLO];
    assign req[g]     = !lo_q[g][B_MASK] &&
                        (lvl[g] ? (asrt[g] && !insvc_q[g]) : pend_q[g]);
    assign eoi_hit[g] = eoi_wr && lvl[g] && (lo_q[g][7:0] == reg_wdata[7:0]);
  end

  assign grant = req & (~req + 1'b1);
  assign issue = (|req) && !msg_valid;

  always_comb begin
    win_idx = '0;
    for (int i = NUM_LINES-1; i >= 0; i--)
      if (req[i]) win_idx = LW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q   <= '0;
      sync2_q   <= '0;
      asrt_q    <= '0;
      pend_q    <= '0;
      insvc_q   <= '0;
      sel_q     <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        lo_q[i] <= 32'h0001_0000;
        hi_q[i] <= 32'h0;
      end
    end else begin
      sync1_q <= irq_in;
      sync2_q <= sync1_q;
      asrt_q  <= asrt;
      pend_q  <= (pend_q & ~(issue ? grant : '0)) | (asrt & ~asrt_q);
      insvc_q <= (insvc_q & ~eoi_hit) | (issue ? (grant & lvl) : '0);
      if (reg_wr && reg_addr == OFF_SEL) sel_q <= reg_wdata[7:0];
      if (reg_wr && reg_addr == OFF_WIN && sel_entry) begin
        if (sel_q[0]) hi_q[sel_line] <= reg_wdata;
        else          lo_q[sel_line] <= reg_wdata;
      end
      if (issue) begin
        msg_valid <= 1'b1;
        msg_addr  <= MSG_BASE | ({16'h0, hi_q[win_idx][31:16]} << 12);
        msg_data  <= {24'h0, lo_q[win_idx][7:0]};
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end
endmodule

module irq_msg_redirector_chk #(
  parameter int          NUM_LINES = 8,
  parameter logic [31:0] MSG_BASE  = 32'hF000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic [7:0]  sel_q,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [31:0] msg_addr,
  input logic [31:0] msg_data
);
  localparam logic [31:0] ID_FIELD = 32'h0FFF_F000;

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !msg_valid);

  // R2
  version_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h10 && sel_q == 8'h01) |-> reg_rdata[23:16] == 8'(NUM_LINES-1));

  // R4
  msg_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((msg_addr & ~ID_FIELD) == (MSG_BASE & ~ID_FIELD)) && msg_data[31:8] == 24'h0);

  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
endmodule

bind irq_msg_redirector irq_msg_redirector_chk #(.NUM_LINES(NUM_LINES), .MSG_BASE(MSG_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .sel_q(sel_q),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

// File: tb/test_irq_msg_redirector.sv
module test_irq_msg_redirector;
  localparam int N = 8;
  localparam logic [31:0] BASE = 32'hF000_0000;

  logic clk = 0, rst_n = 0, reg_wr = 0, msg_ready = 1;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, msg_addr, msg_data;
  logic [N-1:0] irq_in = '0;
  logic msg_valid;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_msg_redirector #(.NUM_LINES(N), .VERSION(8'h21), .MSG_BASE(BASE)) i_irq_msg_redirector (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd_win(input logic [7:0] idx, output logic [31:0] d);
    wr(8'h00, {24'h0, idx});
    rd(8'h10, d);
  endtask

  task automatic set_entry(input int line, input logic [31:0] lo, input logic [31:0] hi);
    wr(8'h00, 32'(16 + 2*line + 1)); wr(8'h10, hi);
    wr(8'h00, 32'(16 + 2*line));     wr(8'h10, lo);
  endtask

  task automatic set_lo(input int line, input logic [31:0] lo);
    wr(8'h00, 32'(16 + 2*line)); wr(8'h10, lo);
  endtask

  task automatic wait_msg(input int maxc, output bit got, output logic [31:0] a, output logic [31:0] d);
    got = 0; a = 0; d = 0;
    for (int i = 0; i < maxc && !got; i++) begin
      @(negedge clk);
      if (msg_valid) begin got = 1; a = msg_addr; d = msg_data; end
    end
    if (got && msg_ready) @(posedge clk);
  endtask

  task automatic expect_msg(input string req, input logic [31:0] ea, input logic [31:0] ed);
    bit got; logic [31:0] a, d;
    wait_msg(12, got, a, d);
    check(got, {req, " message present"}, 32'(got), 1);
    check(d == ed, {req, " data"}, d, ed);
    check(a == ea, {req, " address"}, a, ea);
  endtask

  task automatic expect_none(input string req, input int cyc);
    bit got; logic [31:0] a, d;
    wait_msg(cyc, got, a, d);
    check(!got, {req, " no message"}, d, 0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check(msg_valid == 0, "R1 valid", 32'(msg_valid), 0);
    rd(8'h00, v); check(v == 0, "R1 select", v, 0);
    rd_win(8'h16, v); check(v == 32'h0001_0000, "R1 low word masked", v, 32'h0001_0000);
    rd_win(8'h17, v); check(v == 0, "R1 high word", v, 0);
  endtask

  task automatic t_version;
    logic [31:0] v;
    rd_win(8'h01, v); check(v == 32'h0007_0021, "R2 version", v, 32'h0007_0021);
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, v); check(v == 32'h0007_0021, "R2 read-only", v, 32'h0007_0021);
  endtask

  task automatic t_window;
    logic [31:0] v;
    set_entry(3, 32'h0001_8042, 32'h1234_5678);
    rd_win(8'h16, v); check(v == 32'h0001_8042, "R3 low readback", v, 32'h0001_8042);
    rd_win(8'h17, v); check(v == 32'h1234_5678, "R3 high readback", v, 32'h1234_5678);
    wr(8'h00, 32'h05); wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); check(v == 0, "R3 unused index", v, 0);
    rd(8'h00, v); check(v == 32'h05, "R3 select readback", v, 32'h05);
  endtask

  task automatic t_edge;
    set_entry(2, 32'h0000_0033, 32'hA53C_0000);
    irq_in[2] = 1;
    expect_msg("R4 R5 first edge", BASE | 32'h0A53_C000, 32'h33);
    expect_none("R5 held line", 20);
    @(negedge clk); irq_in[2] = 0;
    repeat (5) @(negedge clk);
    irq_in[2] = 1;
    expect_msg("R5 second edge", BASE | 32'h0A53_C000, 32'h33);
    irq_in[2] = 0;
    expect_none("R5 release", 10);
    set_lo(2, 32'h0001_0033);
  endtask

  task automatic t_level;
    set_entry(4, 32'h0000_8044, 32'h0102_0000);
    irq_in[4] = 1;
    expect_msg("R6 level first", BASE | 32'h0010_2000, 32'h44);
    expect_none("R6 blocked in service", 20);
    wr(8'h40, 32'h44);
    expect_msg("R6 EOI while asserted", BASE | 32'h0010_2000, 32'h44);
    @(negedge clk); irq_in[4] = 0;
    repeat (6) @(negedge clk);
    wr(8'h40, 32'h44);
    expect_none("R6 EOI after release", 20);
    set_lo(4, 32'h0001_8044);
  endtask

  task automatic t_eoi_match;
    set_entry(5, 32'h0000_8055, 32'h0);
    set_entry(6, 32'h0000_8066, 32'h0);
    @(negedge clk); irq_in[5] = 1; irq_in[6] = 1;
    expect_msg("R7 line5", BASE, 32'h55);
    expect_msg("R7 line6", BASE, 32'h66);
    expect_none("R7 both in service", 15);
    wr(8'h40, 32'h66);
    expect_msg("R7 matching EOI", BASE, 32'h66);
    expect_none("R7 other line still blocked", 15);
    wr(8'h40, 32'h55);
    expect_msg("R7 second EOI", BASE, 32'h55);
    @(negedge clk); irq_in[5] = 0; irq_in[6] = 0;
    set_lo(5, 32'h0001_8055); set_lo(6, 32'h0001_8066);
  endtask

  task automatic t_polarity;
    @(negedge clk); irq_in[1] = 1;
    repeat (5) @(negedge clk);
    set_entry(1, 32'h0000_A011, 32'h0);
    expect_none("R8 active-low idle high", 12);
    @(negedge clk); irq_in[1] = 0;
    expect_msg("R8 active-low asserted", BASE, 32'h11);
    set_lo(1, 32'h0001_A011);
    @(negedge clk); irq_in[1] = 1;
    repeat (4) @(negedge clk);
    set_lo(1, 32'h0001_0011);
    @(negedge clk); irq_in[1] = 0;
  endtask

  task automatic t_mask;
    set_entry(7, 32'h0001_0077, 32'h0);
    @(negedge clk); irq_in[7] = 1;
    repeat (6) @(negedge clk);
    irq_in[7] = 0;
    expect_none("R9 masked", 20);
    set_lo(7, 32'h0000_0077);
    expect_msg("R9 pending sent on unmask", BASE, 32'h77);
    expect_none("R9 sent once", 10);
    set_lo(7, 32'h0001_0077);
  endtask

  task automatic t_priority;
    bit got; logic [31:0] a, d;
    set_entry(0, 32'h0000_000A, 32'h0);
    set_entry(3, 32'h0000_003B, 32'h0);
    @(negedge clk); msg_ready = 0; irq_in[0] = 1; irq_in[3] = 1;
    wait_msg(12, got, a, d);
    check(got && d == 32'h0A, "R10 lowest line first", d, 32'h0A);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(msg_valid && msg_data == 32'h0A, "R10 held under back-pressure", msg_data, 32'h0A);
    end
    msg_ready = 1;
    expect_msg("R10 next line", BASE, 32'h3B);
    irq_in[0] = 0; irq_in[3] = 0;
    set_lo(0, 32'h0001_000A); set_lo(3, 32'h0001_003B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_version();
    t_window();
    t_edge();
    t_level();
    t_eoi_match();
    t_polarity();
    t_mask();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule